// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block holds the operating mode of a small microcontroller and decides which mode comes next. The CPU sends it a one-cycle strobe when it executes a SLEEP instruction. An interrupt controller sends a one-cycle strobe to wake the part. Five control bits steer each decision: a direct-transfer enable, a standby select, a medium-speed select, a low-speed select and a watch-timer select.

There are two running speeds and one subclock running mode. The four halted modes are sleep, subsleep, standby and watch. When direct transfer is enabled, certain combinations of the control bits let a SLEEP hop straight between the running modes without halting. Any other SLEEP enters one of the halted modes, and the wake strobe leaves it again.

The block drives a one-hot mode vector, a CPU-halt flag and a clock-source code. It does not generate clocks, count oscillator settling time or decode a register bus.

Top module: `lpm_mode_ctrl`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, the mode is active high-speed. In that state mode_onehot is 7'b0000001, clk_src is 2'b00 and cpu_halt is 0.
- R2: mode_onehot always has exactly one bit set. The bits are: bit0 high-speed, bit1 medium-speed, bit2 subactive, bit3 sleep, bit4 subsleep, bit5 standby, bit6 watch. cpu_halt is 1 exactly when one of bits 3 to 6 is set.
- R3: clk_src reads 2'b00 (high-speed) in high-speed and 2'b01 (medium-speed) in medium-speed. It reads 2'b10 (subclock) in subactive, subsleep, standby and watch. In sleep it reads the code of the active mode that sleep was entered from.
- R4: With direct_en=0, a SLEEP in either active mode goes to sleep when standby_sel=0. It goes to standby when standby_sel=1 and watch_sel=0, and to watch when standby_sel=1 and watch_sel=1.
- R5: With direct_en=0, a SLEEP in subactive goes to subsleep when standby_sel=0, and to watch when standby_sel=1.
- R6: With direct_en=1, a SLEEP in high-speed goes to medium-speed when standby_sel=0, medium_sel=1 and low_sel=0. It goes to subactive when standby_sel=1, watch_sel=1 and low_sel=1.
- R7: With direct_en=1, a SLEEP in medium-speed goes to high-speed when standby_sel=0, medium_sel=0 and low_sel=0. It goes to subactive when standby_sel=1, watch_sel=1 and low_sel=1.
- R8: With direct_en=1, standby_sel=1, watch_sel=1 and low_sel=0, a SLEEP in subactive goes to medium-speed if medium_sel=1 and to high-speed if medium_sel=0.
- R9: With direct_en=1 and no direct combination matching, a SLEEP follows the rules of R4 and R5.
- R10: A wake strobe returns sleep to the active mode it came from, subsleep to subactive and standby to high-speed. It returns watch to subactive if low_sel=1; otherwise it goes to medium-speed if medium_sel=1 and to high-speed if medium_sel=0.
- R11: A mode change happens on the clock edge that samples the strobe. A sleep strobe in a halted mode has no effect, and neither does a wake strobe in a running mode. With no strobe the mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe: the CPU executed SLEEP |
| wake_req | input | 1 | One-cycle wake-up interrupt strobe |
| direct_en | input | 1 | Enables direct transfer between running modes |
| standby_sel | input | 1 | Standby select control bit |
| medium_sel | input | 1 | Medium-speed select control bit |
| low_sel | input | 1 | Low-speed (subclock) select control bit |
| watch_sel | input | 1 | Watch-timer select control bit |
| mode_onehot | output | 7 | One-hot current mode |
| cpu_halt | output | 1 | CPU halted |
| clk_src | output | 2 | Clock source: 00 high, 01 medium, 10 subclock |

## Verification
The bench begins with a directed walk through every direct hop between the running modes. It then enters each halted mode and wakes from it, so each mode can be told apart from the modes it could be mistaken for. Sleep is entered from both active speeds, which shows whether the origin speed is remembered. Watch is woken under each medium_sel and low_sel setting, and strobes are applied in modes where they do not apply. A long run of seeded random strobes and control bits, compared every cycle against a behavioural model, catches combinations the directed walk misses, including fall-back from a non-matching direct combination.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NUM_MODES = 7;
  localparam int MODE_W    = $clog2(NUM_MODES);
  localparam int CLKSRC_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    M_HIGH     = 3'd0,
    M_MEDIUM   = 3'd1,
    M_SUB      = 3'd2,
    M_SLEEP    = 3'd3,
    M_SUBSLEEP = 3'd4,
    M_STANDBY  = 3'd5,
    M_WATCH    = 3'd6
  } mode_e;

  localparam logic [CLKSRC_W-1:0] SRC_HIGH   = 2'b00;
  localparam logic [CLKSRC_W-1:0] SRC_MEDIUM = 2'b01;
  localparam logic [CLKSRC_W-1:0] SRC_SUBCLK = 2'b10;

  typedef struct packed {
    logic direct_en;
    logic standby_sel;
    logic medium_sel;
    logic low_sel;
    logic watch_sel;
  } ctl_t;
endpackage

// File: rtl/lpm_next_mode.sv
module lpm_next_mode
  import lpm_pkg::*;
(
  input  mode_e cur_mode,
  input  logic  cur_from_med,
  input  logic  sleep_req,
  input  logic  wake_req,
  input  ctl_t  ctl,
  output mode_e nxt_mode,
  output logic  nxt_from_med
);
  logic run_hop_med;
  logic run_hop_high;
  logic run_hop_sub;
  logic sub_hop;
  mode_e active_halt;
  mode_e sub_halt;

  always_comb begin
    run_hop_med  = ctl.direct_en & ~ctl.standby_sel & ctl.medium_sel & ~ctl.low_sel;
    run_hop_high = ctl.direct_en & ~ctl.standby_sel & ~ctl.medium_sel & ~ctl.low_sel;
    run_hop_sub  = ctl.direct_en & ctl.standby_sel & ctl.watch_sel & ctl.low_sel;
    sub_hop      = ctl.direct_en & ctl.standby_sel & ctl.watch_sel & ~ctl.low_sel;

    if (!ctl.standby_sel)    active_halt = M_SLEEP;
    else if (!ctl.watch_sel) active_halt = M_STANDBY;
    else                     active_halt = M_WATCH;

    sub_halt = ctl.standby_sel ? M_WATCH : M_SUBSLEEP;
  end

  always_comb begin
    nxt_mode     = cur_mode;
    nxt_from_med = cur_from_med;
    unique case (cur_mode)
      M_HIGH: if (sleep_req) begin
        if (run_hop_med)      nxt_mode = M_MEDIUM;
        else if (run_hop_sub) nxt_mode = M_SUB;
        else begin
          nxt_mode     = active_halt;
          nxt_from_med = 1'b0;
        end
      end
      M_MEDIUM: if (sleep_req) begin
        if (run_hop_high)     nxt_mode = M_HIGH;
        else if (run_hop_sub) nxt_mode = M_SUB;
        else begin
          nxt_mode     = active_halt;
          nxt_from_med = 1'b1;
        end
      end
      M_SUB: if (sleep_req) begin
        if (sub_hop) nxt_mode = ctl.medium_sel ? M_MEDIUM : M_HIGH;
        else         nxt_mode = sub_halt;
      end
      M_SLEEP:    if (wake_req) nxt_mode = cur_from_med ? M_MEDIUM : M_HIGH;
      M_SUBSLEEP: if (wake_req) nxt_mode = M_SUB;
      M_STANDBY:  if (wake_req) nxt_mode = M_HIGH;
      M_WATCH: if (wake_req) begin
        if (ctl.low_sel)         nxt_mode = M_SUB;
        else if (ctl.medium_sel) nxt_mode = M_MEDIUM;
        else                     nxt_mode = M_HIGH;
      end
      default: nxt_mode = M_HIGH;
    endcase
  end
endmodule

// File: rtl/lpm_out_decode.sv
module lpm_out_decode
  import lpm_pkg::*;
(
  input  mode_e                 mode,
  input  logic                  from_med,
  output logic [NUM_MODES-1:0]  onehot,
  output logic                  halt,
  output logic [CLKSRC_W-1:0]   src
);
  for (genvar i = 0; i < NUM_MODES; i++) begin : g_bit
    assign onehot[i] = (mode == mode_e'(i));
  end

  assign halt = |onehot[NUM_MODES-1:int'(M_SLEEP)];

  always_comb begin
    unique case (mode)
      M_HIGH:   src = SRC_HIGH;
      M_MEDIUM: src = SRC_MEDIUM;
      M_SLEEP:  src = from_med ? SRC_MEDIUM : SRC_HIGH;
      default:  src = SRC_SUBCLK;
    endcase
  end
endmodule

// File: rtl/lpm_mode_ctrl.sv
module lpm_mode_ctrl
  import lpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sleep_req,
  input  logic                 wake_req,
  input  logic                 direct_en,
  input  logic                 standby_sel,
  input  logic                 medium_sel,
  input  logic                 low_sel,
  input  logic                 watch_sel,
  output logic [NUM_MODES-1:0] mode_onehot,
  output logic                 cpu_halt,
  output logic [CLKSRC_W-1:0]  clk_src
);
  mode_e mode_q, mode_d;
  logic  from_med_q, from_med_d;
  logic  state_en;
  ctl_t  ctl;

  assign ctl = '{direct_en:   direct_en,
                 standby_sel: standby_sel,
                 medium_sel:  medium_sel,
                 low_sel:     low_sel,
                 watch_sel:   watch_sel};

  assign state_en = sleep_req | wake_req;

  lpm_next_mode u_next (
    .cur_mode     (mode_q),
    .cur_from_med (from_med_q),
    .sleep_req    (sleep_req),
    .wake_req     (wake_req),
    .ctl          (ctl),
    .nxt_mode     (mode_d),
    .nxt_from_med (from_med_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= M_HIGH;
      from_med_q <= 1'b0;
    end else if (state_en) begin
      mode_q     <= mode_d;
      from_med_q <= from_med_d;
    end
  end

  lpm_out_decode u_dec (
    .mode     (mode_q),
    .from_med (from_med_q),
    .onehot   (mode_onehot),
    .halt     (cpu_halt),
    .src      (clk_src)
  );
endmodule

// File: rtl/lpm_mode_ctrl_chk.sv
module lpm_mode_ctrl_chk
  import lpm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sleep_req,
  input logic                 wake_req,
  input logic                 direct_en,
  input logic                 standby_sel,
  input logic                 medium_sel,
  input logic                 low_sel,
  input logic                 watch_sel,
  input logic [NUM_MODES-1:0] mode_onehot,
  input logic                 cpu_halt,
  input logic [CLKSRC_W-1:0]  clk_src
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_onehot) == 1);

  p_halt_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt == (|mode_onehot[6:3]));

  p_subclk_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_onehot[2] | mode_onehot[4] | mode_onehot[5] | mode_onehot[6]) |-> clk_src == SRC_SUBCLK);

  p_hop_high_med_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_onehot[0] && sleep_req && direct_en && !standby_sel && medium_sel && !low_sel)
    |=> mode_onehot[1]);

  p_hop_med_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_onehot[1] && sleep_req && direct_en && standby_sel && watch_sel && low_sel)
    |=> mode_onehot[2]);

  p_subsleep_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_onehot[4] && wake_req) |=> mode_onehot[2]);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_req && !wake_req) |=> $stable(mode_onehot));

  p_halt_ignores_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halt && sleep_req && !wake_req) |=> $stable(mode_onehot));
endmodule

bind lpm_mode_ctrl lpm_mode_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .wake_req    (wake_req),
  .direct_en   (direct_en),
  .standby_sel (standby_sel),
  .medium_sel  (medium_sel),
  .low_sel     (low_sel),
  .watch_sel   (watch_sel),
  .mode_onehot (mode_onehot),
  .cpu_halt    (cpu_halt),
  .clk_src     (clk_src)
);

// File: tb/lpm_mode_ctrl_bench.sv
module lpm_mode_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0;
  logic direct_en = 1'b0, standby_sel = 1'b0, medium_sel = 1'b0;
  logic low_sel = 1'b0, watch_sel = 1'b0;
  logic [6:0] mode_onehot;
  logic       cpu_halt;
  logic [1:0] clk_src;

  int checks = 0;
  int fails  = 0;

  // reference state: 0 high,1 medium,2 sub,3 sleep,4 subsleep,5 standby,6 watch
  int    ref_mode = 0;
  int    ref_origin = 0;
  string ref_tag = "R1";

  always #5 clk = ~clk;

  lpm_mode_ctrl u_lpm_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
    .direct_en(direct_en), .standby_sel(standby_sel), .medium_sel(medium_sel),
    .low_sel(low_sel), .watch_sel(watch_sel),
    .mode_onehot(mode_onehot), .cpu_halt(cpu_halt), .clk_src(clk_src)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mode <= 0; ref_origin <= 0; ref_tag <= "R1";
    end else begin
      int    m;
      int    o;
      string t;
      m = ref_mode; o = ref_origin; t = "R11";
      if (ref_mode <= 1 && sleep_req) begin
        if (direct_en && ref_mode == 0 && !standby_sel && medium_sel && !low_sel) begin
          m = 1; t = "R6";
        end else if (direct_en && ref_mode == 1 && !standby_sel && !medium_sel && !low_sel) begin
          m = 0; t = "R7";
        end else if (direct_en && standby_sel && watch_sel && low_sel) begin
          m = 2; t = (ref_mode == 0) ? "R6" : "R7";
        end else begin
          o = ref_mode;
          t = direct_en ? "R9" : "R4";
          m = !standby_sel ? 3 : (watch_sel ? 6 : 5);
        end
      end else if (ref_mode == 2 && sleep_req) begin
        if (direct_en && standby_sel && watch_sel && !low_sel) begin
          m = medium_sel ? 1 : 0; t = "R8";
        end else begin
          m = standby_sel ? 6 : 4; t = direct_en ? "R9" : "R5";
        end
      end else if (ref_mode >= 3 && wake_req) begin
        t = "R10";
        case (ref_mode)
          3: m = ref_origin;
          4: m = 2;
          5: m = 0;
          default: m = low_sel ? 2 : (medium_sel ? 1 : 0);
        endcase
      end
      ref_mode <= m; ref_origin <= o; ref_tag <= t;
    end
  end

  function automatic logic [1:0] exp_src(int m, int o);
    if (m == 0) return 2'b00;
    if (m == 1) return 2'b01;
    if (m == 3) return (o == 1) ? 2'b01 : 2'b00;
    return 2'b10;
  endfunction

  task automatic compare(string tag);
    logic [6:0] eo;
    logic       eh;
    logic [1:0] es;
    eo = 7'b1 << ref_mode;
    eh = (ref_mode >= 3);
    es = exp_src(ref_mode, ref_origin);
    checks++;
    if (mode_onehot !== eo || cpu_halt !== eh || clk_src !== es) begin
      fails++;
      $display("FAIL %s (R2/R3 outputs): got mode=%b halt=%b src=%b expected mode=%b halt=%b src=%b",
               tag, mode_onehot, cpu_halt, clk_src, eo, eh, es);
    end
  endtask

  // ctl bits: {direct_en, standby_sel, medium_sel, low_sel, watch_sel}
  task automatic step(logic s, logic w, logic [4:0] c);
    {direct_en, standby_sel, medium_sel, low_sel, watch_sel} = c;
    sleep_req = s; wake_req = w;
    @(posedge clk);
    @(negedge clk);
    sleep_req = 1'b0; wake_req = 1'b0;
    compare(ref_tag);
  endtask

  initial begin
    #20000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");             // held in reset
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");             // first cycle after reset
    // R6: high -> medium by direct hop
    step(1, 0, 5'b10100);
    // R7: medium -> high
    step(1, 0, 5'b10000);
    // R6: high -> sub
    step(1, 0, 5'b11011);
    // R8: sub -> medium
    step(1, 0, 5'b11101);
    // R7: medium -> sub
    step(1, 0, 5'b11011);
    // R8: sub -> high
    step(1, 0, 5'b11001);
    // R4: high -> sleep, R10 wake -> high
    step(1, 0, 5'b00000);
    step(1, 0, 5'b01011);      // R11: sleep strobe ignored while halted
    step(0, 1, 5'b00000);
    // R4 from medium: sleep remembers medium (R3), wake back to medium (R10)
    step(1, 0, 5'b10100);
    step(1, 0, 5'b00100);
    step(0, 0, 5'b00000);
    step(0, 1, 5'b00000);
    step(0, 1, 5'b00000);      // R11: wake ignored while running
    // R4: standby, R10 wake -> high
    step(1, 0, 5'b01000);
    step(0, 1, 5'b00110);
    // R4: watch, R10 wake with low_sel -> sub
    step(1, 0, 5'b01001);
    step(0, 1, 5'b00010);
    // R5: subsleep and back
    step(1, 0, 5'b00000);
    step(0, 1, 5'b00000);
    // R5: watch, R10 wake medium
    step(1, 0, 5'b01000);
    step(0, 1, 5'b00100);
    // R9: direct_en set but no match from medium -> standby
    step(1, 0, 5'b11100);
    step(0, 1, 5'b00000);
    // R9: from sub with direct_en but standby_sel=0 -> subsleep
    step(1, 0, 5'b11011);
    step(1, 0, 5'b10000);
    step(0, 1, 5'b00000);
    // random phase, all requirements
    void'($urandom(32'd7));
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] c;
      int r;
      c = 5'($urandom);
      r = $urandom % 8;
      step(r < 3, (r >= 3 && r < 6) || r == 7, c);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule